// File: doc/BRIEF.md
# Convergence Frame Retrace Window Generator

This block marks the retrace interval of a convergence-correction system with a single gating flag. Three single-cycle strobes from the timebase drive it: a TV-line strobe, a frame strobe and a convergence grid-line strobe. The flag opens a programmable number of TV lines after the eleventh grid line of a frame. It closes a programmable number of TV lines, plus a fixed lead of two, after the following frame strobe. The correction waveform logic uses the flag to hold its outputs steady while the beam returns to the top of the screen.

The two offsets are captured into shadow registers on every frame strobe, so software may rewrite them at any time without tearing a window. A frame whose start sequence is cut short by the next frame strobe produces no window. The grid-line and TV-line counts are brought out for debug. All pins are plain control and status signals. There is no data stream, so no valid/ready handshake applies.

Top module: `frw_window_gen`

## Requirements
- R1: After reset, `win_o` is 0 and both `dbg_grid_cnt_o` and `dbg_line_cnt_o` are 0.
- R2: `dbg_line_cnt_o` clears on a frame strobe and rises by one on each line strobe, saturating at its all-ones value. `dbg_grid_cnt_o` clears on a frame strobe and rises by one on each grid strobe, saturating at all-ones (31 with 5 bits).
- R3: Once the eleventh grid strobe since the last frame strobe has occurred, `win_o` rises on line strobe number S+1 after it, where S is the start offset captured at that frame strobe. With ten or fewer grid strobes in a frame, `win_o` never rises in that frame.
- R4: When a frame strobe has occurred while `win_o` is high, `win_o` falls on the line strobe that brings `dbg_line_cnt_o` to 2+P, where P is the 9-bit stop offset captured at that frame strobe. This covers P = 511 (closing count 513).
- R5: A frame strobe while `win_o` is high does not lower it. The line count passing 2+P in the frame where the window opened does not lower it either.
- R6: If a frame strobe arrives after the eleventh grid strobe but before the opening line strobe, that start is dropped and `win_o` stays 0 through the next frame until its own eleventh grid strobe.
- R7: `start_ofs_i` and `stop_ofs_i` take effect only at frame strobes. Changes between frame strobes do not alter the pending open or close line.
- R8: `win_o` is a register that changes only at the clock edge that samples a line strobe. Grid or frame strobes alone never change it.
- R9: A frame strobe sampled together with a line or grid strobe takes priority. Both counts clear, and the coincident strobe is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| line_pulse_i | input | 1 | One-cycle strobe per TV line |
| frame_pulse_i | input | 1 | One-cycle strobe per frame |
| grid_pulse_i | input | 1 | One-cycle strobe per convergence grid line |
| start_ofs_i | input | 8 | TV lines from the eleventh grid line to window opening |
| stop_ofs_i | input | 9 | TV lines added to the two-line lead after the frame strobe |
| win_o | output | 1 | Retrace window flag |
| dbg_grid_cnt_o | output | 5 | Grid strobes since the last frame strobe |
| dbg_line_cnt_o | output | 10 | Line strobes since the last frame strobe |

## Verification
A wrong start-delay count or a missed arm shows on `win_o` as an opening displaced by whole lines, or an opening that never comes. This is visible at the line strobe where the opening was due. A corrupted line count or stop shadow moves the falling edge. The line count appears on `dbg_line_cnt_o` at the next clock, so a miscount is visible one cycle after the faulty strobe. The close-pending flag has no port of its own. If it is lost, `win_o` either falls in the frame it opened or never falls. Either outcome is seen at the first line strobe that meets the closing count.

// File: rtl/frw_pkg.sv
package frw_pkg;

  // Progress of the window opening within one frame
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,  // waiting for the arming grid line
    ST_DELAY = 2'd1,  // counting TV lines down to the opening
    ST_DONE  = 2'd2   // opened in this frame; nothing more until next frame
  } open_st_e;

  localparam int unsigned GRID_ARM_DEFAULT = 11;
  localparam int unsigned STOP_LEAD_DEFAULT = 2;

endpackage

// File: rtl/frw_grid_tracker.sv
module frw_grid_tracker #(
  parameter int unsigned GRID_W     = 5,
  parameter int unsigned GRID_START = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_pulse_i,
  input  logic              grid_pulse_i,
  output logic [GRID_W-1:0] cnt_o,
  output logic              arm_o
);

  localparam logic [GRID_W-1:0] CNT_MAX = {GRID_W{1'b1}};
  localparam logic [GRID_W-1:0] ARM_AT  = GRID_W'(GRID_START - 1);

  logic [GRID_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (frame_pulse_i) begin
      cnt_q <= '0;
    end else if (grid_pulse_i && (cnt_q != CNT_MAX)) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // Arms once per frame: the grid strobe that takes the count to GRID_START
  assign arm_o = grid_pulse_i && !frame_pulse_i && (cnt_q == ARM_AT);
  assign cnt_o = cnt_q;

endmodule

// File: rtl/frw_start_delay.sv
module frw_start_delay
  import frw_pkg::*;
#(
  parameter int unsigned START_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               frame_pulse_i,
  input  logic               line_pulse_i,
  input  logic               arm_i,
  input  logic [START_W-1:0] start_ofs_i,
  output logic               open_o
);

  open_st_e           st_q, st_d;
  logic [START_W-1:0] dly_q, dly_d;
  logic               open_d;

  always_comb begin
    st_d   = st_q;
    dly_d  = dly_q;
    open_d = 1'b0;
    if (frame_pulse_i) begin
      // a new frame drops any start still in progress
      st_d  = ST_IDLE;
      dly_d = '0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (arm_i) begin
            st_d  = ST_DELAY;
            dly_d = start_ofs_i;
          end
        end
        ST_DELAY: begin
          if (line_pulse_i) begin
            if (dly_q == '0) begin
              open_d = 1'b1;
              st_d   = ST_DONE;
            end else begin
              dly_d = dly_q - 1'b1;
            end
          end
        end
        ST_DONE: begin
          st_d = ST_DONE;
        end
        default: begin
          st_d = ST_IDLE;
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      dly_q <= '0;
    end else begin
      st_q  <= st_d;
      dly_q <= dly_d;
    end
  end

  assign open_o = open_d;

endmodule

// File: rtl/frw_line_tracker.sv
module frw_line_tracker #(
  parameter int unsigned LINE_W    = 10,
  parameter int unsigned STOP_W    = 9,
  parameter int unsigned STOP_LEAD = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_pulse_i,
  input  logic              line_pulse_i,
  input  logic [STOP_W-1:0] stop_ofs_i,
  output logic [LINE_W-1:0] cnt_o,
  output logic              hit_o
);

  localparam logic [LINE_W-1:0] CNT_MAX = {LINE_W{1'b1}};
  localparam logic [LINE_W-1:0] LEAD    = LINE_W'(STOP_LEAD);

  logic [LINE_W-1:0] cnt_q, cnt_inc, target;

  assign cnt_inc = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + 1'b1;
  assign target  = LEAD + LINE_W'(stop_ofs_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (frame_pulse_i) begin
      cnt_q <= '0;
    end else if (line_pulse_i) begin
      cnt_q <= cnt_inc;
    end
  end

  // The line strobe whose count lands on the closing line
  assign hit_o = line_pulse_i && !frame_pulse_i && (cnt_inc == target);
  assign cnt_o = cnt_q;

endmodule

// File: rtl/frw_window_gen.sv
module frw_window_gen
  import frw_pkg::*;
#(
  parameter int unsigned GRID_W     = 5,
  parameter int unsigned GRID_START = GRID_ARM_DEFAULT,
  parameter int unsigned START_W    = 8,
  parameter int unsigned STOP_W     = 9,
  parameter int unsigned STOP_LEAD  = STOP_LEAD_DEFAULT,
  parameter int unsigned LINE_W     = 10
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               line_pulse_i,
  input  logic               frame_pulse_i,
  input  logic               grid_pulse_i,
  input  logic [START_W-1:0] start_ofs_i,
  input  logic [STOP_W-1:0]  stop_ofs_i,
  output logic               win_o,
  output logic [GRID_W-1:0]  dbg_grid_cnt_o,
  output logic [LINE_W-1:0]  dbg_line_cnt_o
);

  logic [START_W-1:0] start_q;
  logic [STOP_W-1:0]  stop_q;
  logic               arm, open_evt, stop_hit;
  logic               win_q, close_armed_q;

  // Offsets are shadowed at frame boundaries only
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q <= '0;
      stop_q  <= '0;
    end else if (frame_pulse_i) begin
      start_q <= start_ofs_i;
      stop_q  <= stop_ofs_i;
    end
  end

  frw_grid_tracker #(
    .GRID_W    (GRID_W),
    .GRID_START(GRID_START)
  ) u_grid (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .frame_pulse_i(frame_pulse_i),
    .grid_pulse_i (grid_pulse_i),
    .cnt_o        (dbg_grid_cnt_o),
    .arm_o        (arm)
  );

  frw_start_delay #(
    .START_W(START_W)
  ) u_start (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .frame_pulse_i(frame_pulse_i),
    .line_pulse_i (line_pulse_i),
    .arm_i        (arm),
    .start_ofs_i  (start_q),
    .open_o       (open_evt)
  );

  frw_line_tracker #(
    .LINE_W   (LINE_W),
    .STOP_W   (STOP_W),
    .STOP_LEAD(STOP_LEAD)
  ) u_line (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .frame_pulse_i(frame_pulse_i),
    .line_pulse_i (line_pulse_i),
    .stop_ofs_i   (stop_q),
    .cnt_o        (dbg_line_cnt_o),
    .hit_o        (stop_hit)
  );

  // Window register; closing is only allowed after a frame strobe seen while open
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_q         <= 1'b0;
      close_armed_q <= 1'b0;
    end else begin
      if (open_evt) begin
        win_q         <= 1'b1;
        close_armed_q <= 1'b0;
      end else if (win_q && close_armed_q && stop_hit) begin
        win_q         <= 1'b0;
        close_armed_q <= 1'b0;
      end else if (win_q && frame_pulse_i) begin
        close_armed_q <= 1'b1;
      end
    end
  end

  assign win_o = win_q;

endmodule

// File: rtl/frw_window_chk.sv
module frw_window_chk #(
  parameter int unsigned GRID_W     = 5,
  parameter int unsigned GRID_START = 11,
  parameter int unsigned STOP_W     = 9,
  parameter int unsigned STOP_LEAD  = 2,
  parameter int unsigned LINE_W     = 10
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              line_pulse_i,
  input logic              frame_pulse_i,
  input logic              grid_pulse_i,
  input logic              win_o,
  input logic [GRID_W-1:0] dbg_grid_cnt_o,
  input logic [LINE_W-1:0] dbg_line_cnt_o,
  input logic [STOP_W-1:0] stop_q
);

  // R8
  win_line_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !line_pulse_i |=> $stable(win_o));

  // R2
  frame_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_pulse_i |=> (dbg_line_cnt_o == '0) && (dbg_grid_cnt_o == '0));

  // R2
  line_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_pulse_i && !frame_pulse_i && (dbg_line_cnt_o != {LINE_W{1'b1}}))
      |=> dbg_line_cnt_o == $past(dbg_line_cnt_o) + 1'b1);

  // R3
  open_after_arm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(win_o) |-> dbg_grid_cnt_o >= GRID_W'(GRID_START));

  // R4
  close_at_target_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(win_o) |-> dbg_line_cnt_o == LINE_W'(STOP_LEAD) + LINE_W'(stop_q));

  // R9
  grid_frame_prio_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_pulse_i && grid_pulse_i) |=> dbg_grid_cnt_o == '0);

endmodule

bind frw_window_gen frw_window_chk #(
  .GRID_W    (GRID_W),
  .GRID_START(GRID_START),
  .STOP_W    (STOP_W),
  .STOP_LEAD (STOP_LEAD),
  .LINE_W    (LINE_W)
) u_frw_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .line_pulse_i  (line_pulse_i),
  .frame_pulse_i (frame_pulse_i),
  .grid_pulse_i  (grid_pulse_i),
  .win_o         (win_o),
  .dbg_grid_cnt_o(dbg_grid_cnt_o),
  .dbg_line_cnt_o(dbg_line_cnt_o),
  .stop_q        (stop_q)
);

// File: tb/frw_window_gen_bench.sv
`timescale 1ns/1ps
module frw_window_gen_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       line_p = 1'b0, frame_p = 1'b0, grid_p = 1'b0;
  logic [7:0] start_ofs = '0;
  logic [8:0] stop_ofs = '0;
  logic       win;
  logic [4:0] gcnt;
  logic [9:0] lcnt;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  frw_window_gen u_frw_window_gen (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .line_pulse_i  (line_p),
    .frame_pulse_i (frame_p),
    .grid_pulse_i  (grid_p),
    .start_ofs_i   (start_ofs),
    .stop_ofs_i    (stop_ofs),
    .win_o         (win),
    .dbg_grid_cnt_o(gcnt),
    .dbg_line_cnt_o(lcnt)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Each strobe is high for one cycle, then low for one; sampling happens after return
  task automatic line(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) line_p = 1'b1;
      @(negedge clk) line_p = 1'b0;
    end
  endtask

  task automatic grid(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) grid_p = 1'b1;
      @(negedge clk) grid_p = 1'b0;
    end
  endtask

  task automatic frame();
    @(negedge clk) frame_p = 1'b1;
    @(negedge clk) frame_p = 1'b0;
  endtask

  // Brings the window down from any state: close with lead 2, then a quiet frame
  task automatic flush();
    stop_ofs = '0;
    frame();
    line(2);
    frame();
  endtask

  task automatic t_reset();
    chk("R1 win", win, 0);
    chk("R1 grid cnt", gcnt, 0);
    chk("R1 line cnt", lcnt, 0);
  endtask

  task automatic t_basic();
    start_ofs = 8'd3; stop_ofs = 9'd4;
    frame();
    line(5);
    chk("R2 line cnt after 5", lcnt, 5);
    grid(10);
    chk("R2 grid cnt after 10", gcnt, 10);
    grid(1);
    chk("R8 arm alone keeps win low", win, 0);
    line(3);
    chk("R3 closed before line S+1", win, 0);
    line(1);
    chk("R3 open at line S+1", win, 1);
    chk("R2 line cnt", lcnt, 9);
    line(1);
    chk("R5 no close before frame", win, 1);
    frame();
    chk("R5 frame keeps open", win, 1);
    chk("R2 line cnt clear", lcnt, 0);
    chk("R2 grid cnt clear", gcnt, 0);
    line(5);
    chk("R4 open before 2+P", win, 1);
    line(1);
    chk("R4 closed at 2+P", win, 0);
    chk("R4 line cnt at close", lcnt, 6);
    line(10);
    chk("R4 stays closed", win, 0);
  endtask

  task automatic t_offset_sample();
    start_ofs = 8'd2; stop_ofs = 9'd1;
    frame();
    start_ofs = 8'd7; stop_ofs = 9'd9;
    grid(11);
    line(2);
    chk("R7 old start, closed", win, 0);
    line(1);
    chk("R7 old start, open", win, 1);
    frame();
    stop_ofs = 9'd0;
    line(10);
    chk("R7 stop from frame, open", win, 1);
    line(1);
    chk("R7 stop from frame, closed", win, 0);
  endtask

  task automatic t_abandon();
    start_ofs = 8'd5; stop_ofs = 9'd0;
    frame();
    grid(11);
    line(2);
    frame();
    line(10);
    chk("R6 dropped start", win, 0);
    grid(10);
    line(10);
    chk("R6 next frame short of arm", win, 0);
  endtask

  task automatic t_short_grid();
    start_ofs = 8'd0;
    frame();
    grid(10);
    line(20);
    chk("R3 ten grid lines, no open", win, 0);
    grid(1);
    line(1);
    chk("R3 offset zero opens on first line", win, 1);
    flush();
    chk("R3 flushed", win, 0);
  endtask

  task automatic t_priority();
    frame();
    line(3);
    grid(2);
    @(negedge clk) begin frame_p = 1'b1; line_p = 1'b1; grid_p = 1'b1; end
    @(negedge clk) begin frame_p = 1'b0; line_p = 1'b0; grid_p = 1'b0; end
    chk("R9 line cnt clear", lcnt, 0);
    chk("R9 grid cnt clear", gcnt, 0);
    grid(35);
    chk("R2 grid cnt saturates", gcnt, 31);
    flush();
  endtask

  task automatic t_max_stop();
    start_ofs = 8'd0; stop_ofs = 9'd511;
    frame();
    grid(11);
    line(1);
    chk("R3 open for max stop", win, 1);
    frame();
    line(512);
    chk("R4 max stop still open", win, 1);
    chk("R4 max stop cnt", lcnt, 512);
    line(1);
    chk("R4 max stop closed", win, 0);
    chk("R4 max stop close cnt", lcnt, 513);
    flush();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_offset_sample();
    t_abandon();
    t_short_grid();
    t_priority();
    t_max_stop();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule